// File: doc/BRIEF.md
# Trace Message Queue with Overflow Policy

This block sits between the logic that captures memory accesses as trace messages and the serializer that ships them off-chip. It holds up to four messages in a first-word-fall-through queue. The serializer takes a message with a valid/ready handshake. A message counts as handed to the serializer in the cycle that handshake completes.

When the producer offers a message while the queue is full, a configuration bit picks one of two overflow policies. Under the stall policy, the block raises a wait request so the bus holds the producer and nothing is lost. Under the drop policy, the offered message is thrown away. A single overflow mark is then placed in the status field of the next message to leave the queue. The message already taken by the serializer never gets the mark. A sticky overflow bit records any loss until software clears it with a write-one-to-clear pulse.

Messages in direct-data mode carry no status field, so in that mode the status output is all zero and no overflow mark is queued up. The sticky bit still records losses.

Top module: `trace_ovf_fifo`

## Requirements
- R1: After synchronous reset the queue is empty (`out_valid`=0), `in_wait`=0 and `ovf_sticky`=0. Any queued messages and any pending mark are discarded.
- R2: Up to 4 messages are held and leave in arrival order. In trace mode (`cfg_trace`=1), `out_status` bit 1 equals the message's `in_tag` and bit 0 is the overflow mark.
- R3: Under the drop policy (`cfg_stall`=0), a message offered while the queue holds 4 entries is discarded and never appears at the output. `in_wait` stays 0.
- R4: Every discarded message sets `ovf_sticky` to 1 from the next cycle on.
- R5: After a discard in trace mode, the next message to leave the queue shows `out_status` bit 0 = 1.
- R6: A message dequeued in the same cycle as a discard does not carry the mark. The message after it does.
- R7: Several discards before the next dequeue produce exactly one marked message. The mark clears once that message is dequeued.
- R8: `ovf_sticky` clears only when `ovf_clr` is 1 at a clock edge. If a discard and a clear happen in the same cycle, the bit stays set.
- R9: Under the stall policy (`cfg_stall`=1), `in_wait` is 1 in exactly those cycles where `in_valid`=1 and the queue holds 4 entries at the start of the cycle. It follows `in_valid` combinationally.
- R10: Under the stall policy no message is lost and `ovf_sticky` is not set. A waiting message is accepted in the cycle after space appears.
- R11: In direct-data mode (`cfg_trace`=0), `out_status` is 2'b00 and no pending mark is recorded. A later switch to trace mode shows no mark for discards that happened earlier. `ovf_sticky` still sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_stall | input | 1 | Overflow policy: 1 = stall producer, 0 = drop and mark |
| cfg_trace | input | 1 | Message format: 1 = trace mode with status, 0 = direct data |
| ovf_clr | input | 1 | Write-one-to-clear pulse for the sticky overflow bit |
| in_valid | input | 1 | Producer offers a message |
| in_tag | input | 1 | Producer status bit, sent as status bit 1 |
| in_data | input | 16 | Message payload |
| in_wait | output | 1 | Wait request to the producer (stall policy only) |
| out_valid | output | 1 | Queue head is valid |
| out_ready | input | 1 | Serializer accepts the head |
| out_data | output | 16 | Head payload |
| out_status | output | 2 | Head status: bit 1 tag, bit 0 overflow mark |
| ovf_sticky | output | 1 | Sticky overflow flag |

## Verification
A pending mark that is lost shows up at the very next dequeue as a status bit 0 that stays low when it should be high. A pending mark that is never cleared shows up as a second marked message one dequeue later. A fill count that is off by one appears within the burst that fills the queue. It shows either as a fifth payload that should have been dropped or as a wait request raised one message early. The stall and clear paths are checked by holding the condition over several cycles, because a sticky bit that fails to hold shows only after the event that set it.

// File: rtl/trace_ovf_pkg.sv
package trace_ovf_pkg;
    localparam int unsigned MSG_DW  = 16;
    localparam int unsigned Q_DEPTH = 4;
    localparam int unsigned STAT_W  = 2;
    localparam int unsigned OVF_BIT = 0;

    typedef enum logic {
        POL_DROP  = 1'b0,
        POL_STALL = 1'b1
    } ovf_policy_e;

    // Status field of a trace message; ovf sits at bit OVF_BIT (bit 0).
    typedef struct packed {
        logic tag;
        logic ovf;
    } trace_stat_t;

    function automatic trace_stat_t fmt_status(input logic trace_mode,
                                               input logic tag,
                                               input logic ovf);
        trace_stat_t s;
        s = '0;
        if (trace_mode) begin
            s.tag = tag;
            s.ovf = ovf;
        end
        return s;
    endfunction
endpackage

// File: rtl/msg_fifo.sv
module msg_fifo #(
    parameter int unsigned W     = 17,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] fill
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_wr, do_rd;

    assign empty   = (fill == '0);
    assign full    = (fill == CW'(DEPTH));
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/ovf_ctrl.sv
module ovf_ctrl
    import trace_ovf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  ovf_policy_e policy,
    input  logic        trace_mode,
    input  logic        in_valid,
    input  logic        full,
    input  logic        deq,
    input  logic        clr,
    output logic        wait_req,
    output logic        wr_en,
    output logic        pend,
    output logic        sticky
);
    logic drop;

    assign wait_req = (policy == POL_STALL) && in_valid && full;
    assign wr_en    = in_valid && !full;
    assign drop     = (policy == POL_DROP) && in_valid && full;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= 1'b0;
            sticky <= 1'b0;
        end else begin
            // a new loss outranks the dequeue that consumes the old mark
            if (drop && trace_mode) pend <= 1'b1;
            else if (deq)           pend <= 1'b0;
            if (drop)               sticky <= 1'b1;
            else if (clr)           sticky <= 1'b0;
        end
    end
endmodule

// File: rtl/stat_insert.sv
module stat_insert
    import trace_ovf_pkg::*;
(
    input  logic        trace_mode,
    input  logic        tag,
    input  logic        pend,
    output trace_stat_t status
);
    always_comb status = fmt_status(trace_mode, tag, pend);
endmodule

// File: rtl/trace_ovf_fifo.sv
module trace_ovf_fifo
    import trace_ovf_pkg::*;
#(
    parameter int unsigned DATA_W = MSG_DW,
    parameter int unsigned DEPTH  = Q_DEPTH,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_stall,
    input  logic              cfg_trace,
    input  logic              ovf_clr,
    input  logic              in_valid,
    input  logic              in_tag,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_wait,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [STAT_W-1:0] out_status,
    output logic              ovf_sticky
);
    logic [DATA_W:0] head;
    logic            empty, full, wr_en, deq, pend;
    logic [CW-1:0]   fill;
    trace_stat_t     st;

    assign out_valid  = !empty;
    assign deq        = out_valid && out_ready;
    assign out_data   = head[DATA_W-1:0];
    assign out_status = st;

    msg_fifo #(.W(DATA_W + 1), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_data({in_tag, in_data}),
        .rd_en(out_ready), .rd_data(head),
        .empty(empty), .full(full), .fill(fill)
    );

    ovf_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .policy(ovf_policy_e'(cfg_stall)), .trace_mode(cfg_trace),
        .in_valid(in_valid), .full(full), .deq(deq), .clr(ovf_clr),
        .wait_req(in_wait), .wr_en(wr_en), .pend(pend), .sticky(ovf_sticky)
    );

    stat_insert u_stat (
        .trace_mode(cfg_trace), .tag(head[DATA_W]), .pend(pend), .status(st)
    );
endmodule

// File: rtl/trace_ovf_chk.sv
module trace_ovf_chk
    import trace_ovf_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned CW    = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_stall,
    input logic              cfg_trace,
    input logic              ovf_clr,
    input logic              in_valid,
    input logic              in_wait,
    input logic              out_valid,
    input logic              out_ready,
    input logic [STAT_W-1:0] out_status,
    input logic              ovf_sticky,
    input logic [CW-1:0]     fill
);
    logic lose;
    assign lose = in_valid && !cfg_stall && (fill == CW'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH)); // R2
    AST_DROP_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
        !cfg_stall |-> !in_wait); // R3
    AST_STICKY_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_sticky) |-> $past(lose)); // R4
    AST_MARK_NEXT: assert property (@(posedge clk) disable iff (rst)
        (lose && cfg_trace) |=> out_valid && (out_status[OVF_BIT] || !cfg_trace)); // R5
    AST_MARK_ONCE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_status[OVF_BIT] && !lose) |=> !out_status[OVF_BIT]); // R7
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ovf_sticky && !ovf_clr) |=> ovf_sticky); // R8
    AST_WAIT_FULL: assert property (@(posedge clk) disable iff (rst)
        in_wait |-> (fill == CW'(DEPTH)) && in_valid); // R9
    AST_DIRECT_NOSTAT: assert property (@(posedge clk) disable iff (rst)
        !cfg_trace |-> (out_status == '0)); // R11
endmodule

bind trace_ovf_fifo trace_ovf_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .cfg_stall(cfg_stall), .cfg_trace(cfg_trace),
    .ovf_clr(ovf_clr), .in_valid(in_valid), .in_wait(in_wait),
    .out_valid(out_valid), .out_ready(out_ready), .out_status(out_status),
    .ovf_sticky(ovf_sticky), .fill(fill)
);

// File: tb/tb_trace_ovf_fifo.sv
`timescale 1ns/1ps
module tb_trace_ovf_fifo;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_stall = 1'b0, cfg_trace = 1'b1, ovf_clr = 1'b0;
    logic        in_valid = 1'b0, in_tag = 1'b0, out_ready = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_wait, out_valid, ovf_sticky;
    logic [15:0] out_data;
    logic [1:0]  out_status;
    int          checks = 0, failures = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    trace_ovf_fifo dut (
        .clk(clk), .rst(rst), .cfg_stall(cfg_stall), .cfg_trace(cfg_trace),
        .ovf_clr(ovf_clr), .in_valid(in_valid), .in_tag(in_tag),
        .in_data(in_data), .in_wait(in_wait), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_status(out_status),
        .ovf_sticky(ovf_sticky)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(); @(posedge clk); #1; endtask
    task automatic settle(); #1; endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 0; out_ready = 0; ovf_clr = 0;
        tick(); tick();
        rst = 1'b0;
        settle();
    endtask

    task automatic push(input logic tag, input logic [15:0] d,
                        input logic exp_wait, input string req);
        in_valid = 1'b1; in_tag = tag; in_data = d;
        settle();
        chk(req, "in_wait during push", in_wait, exp_wait);
        tick();
        in_valid = 1'b0;
    endtask

    task automatic pop(input logic [15:0] d, input logic [1:0] st, input string req);
        out_ready = 1'b1;
        settle();
        chk(req, "out_valid", out_valid, 1);
        chk(req, "out_data", out_data, d);
        chk(req, "out_status", out_status, st);
        tick();
        out_ready = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "out_valid after reset", out_valid, 0);
        chk("R1", "in_wait after reset", in_wait, 0);
        chk("R1", "sticky after reset", ovf_sticky, 0);
    endtask

    task automatic t_order();
        do_reset(); cfg_stall = 0; cfg_trace = 1;
        push(1, 16'h1111, 0, "R2"); push(0, 16'h2222, 0, "R2"); push(1, 16'h3333, 0, "R2");
        pop(16'h1111, 2'b10, "R2"); pop(16'h2222, 2'b00, "R2"); pop(16'h3333, 2'b10, "R2");
        settle();
        chk("R2", "empty after drain", out_valid, 0);
    endtask

    task automatic t_drop();
        do_reset(); cfg_stall = 0; cfg_trace = 1;
        for (int i = 0; i < 6; i++) push(i[0], 16'hA000 + 16'(i), 0, "R3");
        settle();
        chk("R4", "sticky after drops", ovf_sticky, 1);
        // R5 first out marked, R7 only once despite two drops
        for (int i = 0; i < 4; i++)
            pop(16'hA000 + 16'(i), {i[0], (i == 0)}, (i == 0) ? "R5" : "R7");
        settle();
        chk("R3", "dropped messages absent", out_valid, 0);
        // R8 sticky persists, then clear
        tick(); tick();
        chk("R8", "sticky holds without clear", ovf_sticky, 1);
        ovf_clr = 1; tick(); ovf_clr = 0; settle();
        chk("R8", "sticky cleared by pulse", ovf_sticky, 0);
        for (int i = 0; i < 4; i++) push(0, 16'hB000 + 16'(i), 0, "R8");
        in_valid = 1; in_data = 16'hBEEF; ovf_clr = 1;
        tick();
        in_valid = 0; ovf_clr = 0; settle();
        chk("R8", "set wins over clear", ovf_sticky, 1);
        t_reset();
    endtask

    task automatic t_inflight();
        do_reset(); cfg_stall = 0; cfg_trace = 1;
        for (int i = 0; i < 4; i++) push(0, 16'hC000 + 16'(i), 0, "R6");
        in_valid = 1; in_data = 16'hCFFF; out_ready = 1;
        settle();
        chk("R6", "in-flight head data", out_data, 16'hC000);
        chk("R6", "in-flight head unmarked", out_status, 2'b00);
        tick();
        in_valid = 0; out_ready = 0;
        pop(16'hC001, 2'b01, "R6");
        pop(16'hC002, 2'b00, "R6");
        pop(16'hC003, 2'b00, "R6");
        settle();
        chk("R6", "drained", out_valid, 0);
    endtask

    task automatic t_stall();
        do_reset(); cfg_stall = 1; cfg_trace = 1;
        for (int i = 0; i < 4; i++) push(0, 16'hD000 + 16'(i), 0, "R9");
        settle();
        chk("R9", "no wait when idle and full", in_wait, 0);
        in_valid = 1; in_data = 16'hD004; in_tag = 1;
        settle();
        chk("R9", "wait when full", in_wait, 1);
        tick();
        chk("R9", "wait held", in_wait, 1);
        chk("R10", "no sticky under stall", ovf_sticky, 0);
        in_valid = 0; settle();
        chk("R9", "wait follows in_valid", in_wait, 0);
        in_valid = 1; out_ready = 1; settle();
        chk("R9", "wait while full at cycle start", in_wait, 1);
        tick();
        out_ready = 0; settle();
        chk("R9", "wait drops after space", in_wait, 0);
        tick();
        in_valid = 0;
        pop(16'hD001, 2'b00, "R10"); pop(16'hD002, 2'b00, "R10");
        pop(16'hD003, 2'b00, "R10"); pop(16'hD004, 2'b10, "R10");
        settle();
        chk("R10", "sticky still clear", ovf_sticky, 0);
        chk("R10", "drained", out_valid, 0);
        cfg_stall = 0;
    endtask

    task automatic t_direct();
        do_reset(); cfg_stall = 0; cfg_trace = 0;
        for (int i = 0; i < 5; i++) push(1, 16'hE000 + 16'(i), 0, "R11");
        settle();
        chk("R11", "sticky in direct mode", ovf_sticky, 1);
        for (int i = 0; i < 4; i++) pop(16'hE000 + 16'(i), 2'b00, "R11");
        cfg_trace = 1;
        push(1, 16'hE100, 0, "R11");
        pop(16'hE100, 2'b10, "R11");
    endtask

    initial begin
        t_reset();
        t_order();
        t_drop();
        t_inflight();
        t_stall();
        t_direct();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule